// File: doc/BRIEF.md
# Interrupt Mask and Status Bank

This block sits between a peripheral and the chip's interrupt fabric. It watches a vector of live status lines coming from the peripheral. It latches each condition into a sticky flag, and it raises a single interrupt request whenever a latched flag is also enabled in a mask. Software reaches the block through a small register port. A write has a strobe, an address and data. A read is combinational on the address.

Software controls the mask through three write-only registers. One register only sets mask bits, one only clears them, and one only clears sticky flags. Because of this, no read-modify-write is ever needed, and two software agents can touch different bits without racing. Software can read back the current mask, the sticky flags and the instantaneous status. Reading the flags and the live status together lets software see both what has happened since the last acknowledge and what is true right now.

A parameter selects, for each status bit, how that bit is captured. A bit can be captured on its level, so the flag is set every cycle the line is high. It can also be captured on its rising edge, so the flag is set only when the line goes from low to high. The sticky flags never depend on the mask.

Top module: `irq_bank`

## Requirements
- R1: After reset the mask register (address 2) and the sticky register (address 3) read 0, and `irq_o` is low.
- R2: A write to address 0 sets every mask bit whose data bit is one. Mask bits whose data bit is zero keep their value.
- R3: A write to address 1 clears every mask bit whose data bit is one. Mask bits whose data bit is zero keep their value.
- R4: A read of address 2 returns the current mask.
- R5: Status bits configured for level capture set their sticky flag in every cycle the live line is high. With the default configuration these are bits 7..4. The flag then stays set after the line drops, and it reads back at address 3 whether or not the bit is masked.
- R6: Status bits configured for edge capture set their sticky flag only on a low-to-high transition of the live line. With the default configuration these are bits 3..0. A flag cleared while the line stays high remains clear.
- R7: A write to address 4 clears each sticky flag whose data bit is one. All other flags are left unchanged.
- R8: When a flag's set condition and a clear of that same flag occur in the same cycle, the flag ends up set.
- R9: A read of address 5 returns the live status vector as it is in that cycle, not the sticky value.
- R10: Addresses 0, 1, 4, 6 and 7 read as 0. Writes to addresses 2, 3, 5, 6 and 7 change neither the mask nor the sticky flags.
- R11: `irq_o` is high exactly when at least one bit is set in both the sticky flags and the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 3 | Register address for both reads and writes |
| wr_data | input | NBITS | Write data |
| rd_data | output | NBITS | Combinational read data for `addr` |
| status_i | input | NBITS | Live status lines from the peripheral |
| irq_o | output | 1 | Interrupt request |

## Verification
The capture path is tested with three kinds of stimulus. A single-cycle pulse on level bits shows that the flag persists after the line falls. A line held high across a clear tells edge capture apart from level capture: an edge bit stays clear, while a level bit re-sets at once. A rising edge that lands in the same cycle as its own clear shows whether the set or the clear takes priority. Mask writes combine enabled and disabled bits with zero bits, which shows that only the one bits act. The interrupt is checked both with flags present but unmasked and with flags present and masked. This separates the sticky view from the request.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_MASK_SET = 3'd0,
        REG_MASK_CLR = 3'd1,
        REG_MASK_RD  = 3'd2,
        REG_FLAGS    = 3'd3,
        REG_ACK      = 3'd4,
        REG_LIVE     = 3'd5
    } reg_addr_e;

endpackage

// File: rtl/irq_bank_regdec.sv
module irq_bank_regdec
    import irq_bank_pkg::*;
#(
    parameter int NBITS = 8
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NBITS-1:0]  wr_data,
    input  logic [NBITS-1:0]  mask_q,
    input  logic [NBITS-1:0]  flags_q,
    input  logic [NBITS-1:0]  status_i,
    output logic [NBITS-1:0]  set_mask,
    output logic [NBITS-1:0]  clr_mask,
    output logic [NBITS-1:0]  ack_flags,
    output logic [NBITS-1:0]  rd_data
);

    // Write strobes: only the write-only addresses produce any action.
    always_comb begin
        set_mask  = '0;
        clr_mask  = '0;
        ack_flags = '0;
        if (wr_en) begin
            case (addr)
                REG_MASK_SET: set_mask  = wr_data;
                REG_MASK_CLR: clr_mask  = wr_data;
                REG_ACK:      ack_flags = wr_data;
                default: ;
            endcase
        end
    end

    // Read mux; write-only and unmapped addresses return zero.
    always_comb begin
        case (addr)
            REG_MASK_RD: rd_data = mask_q;
            REG_FLAGS:   rd_data = flags_q;
            REG_LIVE:    rd_data = status_i;
            default:     rd_data = '0;
        endcase
    end

endmodule

// File: rtl/irq_bank_mask.sv
module irq_bank_mask #(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] set_mask,
    input  logic [NBITS-1:0] clr_mask,
    output logic [NBITS-1:0] mask_q
);

    typedef struct packed {
        logic [NBITS-1:0] mask;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.mask = (st_q.mask | set_mask) & ~clr_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_q = st_q.mask;

    AST_MASK_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (|$past(set_mask)) |-> ((mask_q & $past(set_mask)) == $past(set_mask))); // R2
    AST_MASK_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (|$past(clr_mask)) |-> ((mask_q & $past(clr_mask)) == '0)); // R3
    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(set_mask) == '0) && ($past(clr_mask) == '0) |-> $stable(mask_q)); // R2

endmodule

// File: rtl/irq_bank_capture.sv
module irq_bank_capture #(
    parameter int               NBITS    = 8,
    parameter logic [NBITS-1:0] EDGE_SEL = 8'h0F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] status_i,
    input  logic [NBITS-1:0] ack_flags,
    output logic [NBITS-1:0] flags_q
);

    typedef struct packed {
        logic [NBITS-1:0] flags;
        logic [NBITS-1:0] prev;
    } cap_st_t;

    cap_st_t          st_d, st_q;
    logic [NBITS-1:0] hit;

    // Per-bit capture variant chosen by EDGE_SEL.
    for (genvar g = 0; g < NBITS; g++) begin : g_cap
        if (EDGE_SEL[g]) begin : g_edge
            assign hit[g] = status_i[g] & ~st_q.prev[g];
        end else begin : g_level
            assign hit[g] = status_i[g];
        end
    end

    always_comb begin
        st_d       = st_q;
        // The set term is applied after the clear term, so a new event is never lost.
        st_d.flags = (st_q.flags & ~ack_flags) | hit;
        st_d.prev  = status_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_q = st_q.flags;

    AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (|$past(hit)) |-> ((flags_q & $past(hit)) == $past(hit))); // R8
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((flags_q & $past(ack_flags & ~hit)) == '0)); // R7
    AST_FLAGS_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((flags_q & ~$past(flags_q) & ~$past(hit)) == '0)); // R5

endmodule

// File: rtl/irq_bank.sv
module irq_bank
    import irq_bank_pkg::*;
#(
    parameter int               NBITS    = 8,
    parameter logic [NBITS-1:0] EDGE_SEL = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NBITS-1:0]  wr_data,
    output logic [NBITS-1:0]  rd_data,
    input  logic [NBITS-1:0]  status_i,
    output logic              irq_o
);

    logic [NBITS-1:0] set_mask, clr_mask, ack_flags;
    logic [NBITS-1:0] mask_q, flags_q;

    irq_bank_regdec #(.NBITS(NBITS)) u_dec (
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .mask_q    (mask_q),
        .flags_q   (flags_q),
        .status_i  (status_i),
        .set_mask  (set_mask),
        .clr_mask  (clr_mask),
        .ack_flags (ack_flags),
        .rd_data   (rd_data)
    );

    irq_bank_mask #(.NBITS(NBITS)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .mask_q   (mask_q)
    );

    irq_bank_capture #(.NBITS(NBITS), .EDGE_SEL(EDGE_SEL)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .status_i  (status_i),
        .ack_flags (ack_flags),
        .flags_q   (flags_q)
    );

    assign irq_o = |(flags_q & mask_q);

    AST_RESET_CLEAN: assert property (@(posedge clk)
        $rose(rst_n) |-> (mask_q == '0) && (flags_q == '0)); // R1
    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_o); // R11
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q == '0) |-> !irq_o); // R11

endmodule

// File: tb/irq_bank_test.sv
module irq_bank_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [7:0] status_i = 8'h00;
    logic       irq_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk; // 125 MHz

    irq_bank uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .status_i(status_i), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(3'd2, v); check("R1 mask", v, 8'h00);
        rd(3'd3, v); check("R1 sticky", v, 8'h00);
        check("R1 irq", {7'd0, irq_o}, 8'h00);
    endtask

    task automatic t_mask;
        logic [7:0] v;
        wr(3'd0, 8'h05); rd(3'd2, v); check("R2/R4 enable", v, 8'h05);
        wr(3'd0, 8'h02); rd(3'd2, v); check("R2 enable keeps zeros", v, 8'h07);
        wr(3'd1, 8'h04); rd(3'd2, v); check("R3 disable", v, 8'h03);
        wr(3'd1, 8'hFF); rd(3'd2, v); check("R3 disable all", v, 8'h00);
    endtask

    task automatic t_level_irq;
        logic [7:0] v;
        @(negedge clk); status_i = 8'h30;
        rd(3'd5, v); check("R9 live high", v, 8'h30);
        @(negedge clk); status_i = 8'h00;
        @(negedge clk);
        rd(3'd5, v); check("R9 live low", v, 8'h00);
        rd(3'd3, v); check("R5 sticky unmasked", v, 8'h30);
        check("R11 no irq when masked", {7'd0, irq_o}, 8'h00);
        wr(3'd0, 8'h10);
        check("R11 irq when enabled", {7'd0, irq_o}, 8'h01);
        wr(3'd4, 8'h10); rd(3'd3, v); check("R7 clear one", v, 8'h20);
        check("R11 irq drops", {7'd0, irq_o}, 8'h00);
        wr(3'd4, 8'h20); rd(3'd3, v); check("R7 clear other", v, 8'h00);
    endtask

    task automatic t_edge;
        logic [7:0] v;
        @(negedge clk); status_i = 8'h11;
        repeat (3) @(negedge clk);
        rd(3'd3, v); check("R6 edge captured", v, 8'h11);
        wr(3'd4, 8'h11);
        @(negedge clk);
        rd(3'd3, v); check("R6/R5 held line after clear", v, 8'h10);
        @(negedge clk); status_i = 8'h00;
        wr(3'd4, 8'h10); rd(3'd3, v); check("R7 clean", v, 8'h00);
    endtask

    task automatic t_set_wins;
        logic [7:0] v;
        @(negedge clk);
        status_i = 8'h02; wr_en = 1'b1; addr = 3'd4; wr_data = 8'h02;
        @(negedge clk);
        wr_en = 1'b0; status_i = 8'h00;
        rd(3'd3, v); check("R8 set beats clear", v, 8'h02);
        wr(3'd4, 8'h02); rd(3'd3, v); check("R8 later clear", v, 8'h00);
    endtask

    task automatic t_ignored;
        logic [7:0] v;
        @(negedge clk); status_i = 8'h40;
        @(negedge clk); status_i = 8'h00;
        rd(3'd0, v); check("R10 read enable", v, 8'h00);
        rd(3'd1, v); check("R10 read disable", v, 8'h00);
        rd(3'd4, v); check("R10 read clear", v, 8'h00);
        rd(3'd6, v); check("R10 read unmapped 6", v, 8'h00);
        rd(3'd7, v); check("R10 read unmapped 7", v, 8'h00);
        for (int a = 2; a < 8; a++) begin
            if (a != 4) wr(3'(a), 8'hFF);
        end
        rd(3'd2, v); check("R10 mask untouched", v, 8'h10);
        rd(3'd3, v); check("R10 sticky untouched", v, 8'h40);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask();
        t_level_irq();
        t_edge();
        t_set_wins();
        t_ignored();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule